// File: doc/BRIEF.md
# Prioritized Interrupt Encoder and Acknowledge Decoder

This block is the glue between seven devices that raise active-low interrupt requests and a CPU that samples a 3-bit active-low priority level. The priority path is purely combinational. It finds the highest-numbered request that is pulled low and presents that level, inverted, on three level lines. When no request is active, all three lines read high, which means level 0.

On the bus side, the block watches the function-code outputs, the address strobe and the address bus. It recognises the interrupt-acknowledge cycle and lowers exactly one per-level acknowledge line. In the same cycle it drives the acknowledged level's 8-bit vector number onto the low data byte and raises an output enable so that the board can steer that byte onto the data bus. One register per level holds the vectors. The registers take their values from a simple write port and reset to a base value plus the level number.

Every interface here is plain control or status. There is no streaming payload, so no valid/ready handshake is used. The acknowledge outputs and the vector follow the bus inputs combinationally, and the CPU's own strobe timing paces them.

Top module: `irq_glue`

## Requirements
- R1: The level output `ipl_n` equals the bitwise inverse of the highest index i (1..7) for which `req_n[i]` is 0. When every request is high, it reads 3'b111, which is level 0.
- R2: A higher-numbered request hides every lower one, whatever the state of the lower lines. For example, requests on 2 and 6 together give level 6, and the request on 7 always wins.
- R3: An acknowledge cycle needs all three conditions: `as_n` is 0, `fc` is 3'b111, and `addr[23:4]` is all ones. In that cycle, `ack_n[addr[3:1]]` is the only acknowledge line driven low.
- R4: If `fc` takes any value other than 3'b111, every `ack_n` line stays high. This includes the cycle types 3'b001, 3'b010, 3'b101 and 3'b110.
- R5: While `as_n` is 1, every `ack_n` line stays high.
- R6: If `addr[23:4]` is not all ones, or if `addr[3:1]` is 0, no `ack_n` line goes low.
- R7: `vec_oe` is 1 exactly when some `ack_n` line is low. While it is 1, `vec_data` carries the stored vector of the acknowledged level. At all other times `vec_data` is 8'h00.
- R8: After reset, the vector of level L is `VEC_BASE + L`, which is 8'h40 + L with the default parameters.
- R9: If `vec_wr` is 1 at a rising clock edge and `vec_lvl` is between 1 and 7, `vec_wdata` is stored as that level's vector. A write with `vec_lvl` equal to 0 changes no vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the vector registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 7 | Active-low device requests, index 1..7 |
| ipl_n | output | 3 | Active-low encoded priority level to the CPU |
| as_n | input | 1 | Active-low address strobe from the CPU |
| fc | input | 3 | Function code giving the bus cycle type |
| addr | input | 23 | Address bus, bits 23..1 |
| ack_n | output | 7 | Active-low per-level acknowledge, index 1..7 |
| vec_oe | output | 1 | High while a vector is being returned |
| vec_data | output | 8 | Vector number for the low data byte |
| vec_wr | input | 1 | Vector register write enable |
| vec_lvl | input | 3 | Level whose vector is written |
| vec_wdata | input | 8 | Vector value to write |

## Verification
On every clock, the bound checker confirms four things. At most one acknowledge line is low. A high strobe, or any function code other than 3'b111, keeps all acknowledge lines high. The output enable tracks the acknowledge lines, and the vector byte is zero while the enable is low. The checker also confirms that any active request yields a nonzero level. Some behaviours can only be shown by the bench's scenarios: the exact level chosen for each of the 128 request patterns, the reset values of the vectors, the values returned after writes, and the fact that a write to level 0 leaves every stored vector unchanged.

// File: rtl/irq_glue_pkg.sv
package irq_glue_pkg;
  localparam logic [2:0] FC_IACK = 3'b111;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int LVL_W = 3,
  localparam int NLVL = (1 << LVL_W) - 1
) (
  input  logic [NLVL:1]    req_n,
  output logic [LVL_W-1:0] ipl_n
);
  logic [LVL_W-1:0] lvl;

  // Ascending scan: the last active index seen is the highest one.
  always_comb begin
    lvl = '0;
    for (int i = 1; i <= NLVL; i++) begin
      if (!req_n[i]) lvl = LVL_W'(i);
    end
  end

  assign ipl_n = ~lvl;
endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode
  import irq_glue_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int ADDR_HI = 23,
  localparam int NLVL   = (1 << LVL_W) - 1
) (
  input  logic            as_n,
  input  logic [2:0]      fc,
  input  logic [ADDR_HI:1] addr,
  output logic [NLVL:1]   ack_hot
);
  logic cyc_ok;
  logic [LVL_W-1:0] lvl;

  assign lvl    = addr[LVL_W:1];
  assign cyc_ok = !as_n && (fc == FC_IACK) && (&addr[ADDR_HI:LVL_W+1]);

  for (genvar g = 1; g <= NLVL; g++) begin : g_lvl
    assign ack_hot[g] = cyc_ok && (lvl == LVL_W'(g));
  end
endmodule

// File: rtl/irq_vec_bank.sv
module irq_vec_bank #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h40,
  localparam int NLVL = (1 << LVL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic [VEC_W-1:0] wr_data,
  input  logic [NLVL:1]    rd_hot,
  output logic [VEC_W-1:0] rd_data
);
  logic [VEC_W-1:0] vec_q [NLVL:1];

  for (genvar g = 1; g <= NLVL; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vec_q[g] <= VEC_BASE + VEC_W'(g);
      else if (wr && (wr_lvl == LVL_W'(g)))
        vec_q[g] <= wr_data;
    end
  end

  // AND-OR mux driven by the one-hot select.
  always_comb begin
    rd_data = '0;
    for (int i = 1; i <= NLVL; i++) begin
      rd_data = rd_data | (rd_hot[i] ? vec_q[i] : '0);
    end
  end
endmodule

// File: rtl/irq_glue.sv
module irq_glue #(
  parameter int LVL_W   = 3,
  parameter int VEC_W   = 8,
  parameter int ADDR_HI = 23,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [(1<<LVL_W)-1:1]     req_n,
  output logic [LVL_W-1:0]          ipl_n,
  input  logic                      as_n,
  input  logic [2:0]                fc,
  input  logic [ADDR_HI:1]          addr,
  output logic [(1<<LVL_W)-1:1]     ack_n,
  output logic                      vec_oe,
  output logic [VEC_W-1:0]          vec_data,
  input  logic                      vec_wr,
  input  logic [LVL_W-1:0]          vec_lvl,
  input  logic [VEC_W-1:0]          vec_wdata
);
  localparam int NLVL = (1 << LVL_W) - 1;

  logic [NLVL:1] ack_hot;

  irq_prio_enc #(.LVL_W(LVL_W)) u_enc (
    .req_n (req_n),
    .ipl_n (ipl_n)
  );

  irq_ack_decode #(.LVL_W(LVL_W), .ADDR_HI(ADDR_HI)) u_dec (
    .as_n    (as_n),
    .fc      (fc),
    .addr    (addr),
    .ack_hot (ack_hot)
  );

  irq_vec_bank #(.LVL_W(LVL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (vec_wr),
    .wr_lvl  (vec_lvl),
    .wr_data (vec_wdata),
    .rd_hot  (ack_hot),
    .rd_data (vec_data)
  );

  assign ack_n  = ~ack_hot;
  assign vec_oe = |ack_hot;
endmodule

// File: rtl/irq_glue_chk.sv
module irq_glue_chk #(
  parameter int LVL_W   = 3,
  parameter int VEC_W   = 8,
  parameter int ADDR_HI = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [(1<<LVL_W)-1:1] req_n,
  input logic [LVL_W-1:0]      ipl_n,
  input logic                  as_n,
  input logic [2:0]            fc,
  input logic [(1<<LVL_W)-1:1] ack_n,
  input logic                  vec_oe,
  input logic [VEC_W-1:0]      vec_data
);
  a_r3_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ack_n));

  a_r5_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (&ack_n));

  a_r4_other_fc: assert property (@(posedge clk) disable iff (!rst_n)
    (fc != 3'b111) |-> (&ack_n));

  a_r7_oe_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe == !(&ack_n));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_oe |-> (vec_data == '0));

  a_r1_pending_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&req_n)) |-> (ipl_n != '1));
endmodule

bind irq_glue irq_glue_chk #(.LVL_W(LVL_W), .VEC_W(VEC_W), .ADDR_HI(ADDR_HI)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_n    (req_n),
  .ipl_n    (ipl_n),
  .as_n     (as_n),
  .fc       (fc),
  .ack_n    (ack_n),
  .vec_oe   (vec_oe),
  .vec_data (vec_data)
);

// File: tb/irq_glue_test.sv
module irq_glue_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:1]  req_n = '1;
  logic [2:0]  ipl_n;
  logic        as_n = 1'b1;
  logic [2:0]  fc = 3'b001;
  logic [23:1] addr = '0;
  logic [7:1]  ack_n;
  logic        vec_oe;
  logic [7:0]  vec_data;
  logic        vec_wr = 1'b0;
  logic [2:0]  vec_lvl = '0;
  logic [7:0]  vec_wdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_vec [1:7];

  always #2 clk = ~clk;  // 250 MHz

  irq_glue uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .ipl_n(ipl_n),
    .as_n(as_n), .fc(fc), .addr(addr), .ack_n(ack_n),
    .vec_oe(vec_oe), .vec_data(vec_data),
    .vec_wr(vec_wr), .vec_lvl(vec_lvl), .vec_wdata(vec_wdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Run one bus cycle with the given fc/address and check ack and vector.
  task automatic bus_cycle(input logic [2:0] f, input logic [23:1] a,
                           input int exp_lvl, input string req);
    logic [7:1] exp_ack;
    @(negedge clk);
    fc = f; addr = a; as_n = 1'b0;
    #1;
    exp_ack = '1;
    if (exp_lvl != 0) exp_ack[exp_lvl] = 1'b0;
    chk(ack_n == exp_ack, req, ack_n, exp_ack);
    chk(vec_oe == (exp_lvl != 0), req, vec_oe, exp_lvl != 0);
    chk(vec_data == ((exp_lvl != 0) ? exp_vec[exp_lvl] : 8'h00), req, vec_data,
        (exp_lvl != 0) ? exp_vec[exp_lvl] : 8'h00);
    @(negedge clk);
    as_n = 1'b1; fc = 3'b001;
  endtask

  function automatic logic [23:1] iack_addr(input int lvl);
    return {20'hFFFFF, 3'(lvl)};
  endfunction

  task automatic t_reset();
    // R8: vectors default to 0x40 + level
    for (int l = 1; l <= 7; l++) exp_vec[l] = 8'h40 + 8'(l);
    #1;
    chk(ipl_n == 3'b111, "R1 reset idle level", ipl_n, 7);
    chk(ack_n == 7'h7F, "R5 reset ack idle", ack_n, 7'h7F);
    for (int l = 1; l <= 7; l++) bus_cycle(3'b111, iack_addr(l), l, "R8 reset vector");
  endtask

  task automatic t_encode_all();
    // R1, R2: every request pattern
    for (int p = 0; p < 128; p++) begin
      int hi;
      @(negedge clk);
      req_n = 7'(p);
      hi = 0;
      for (int i = 1; i <= 7; i++) if (!req_n[i]) hi = i;
      #1;
      chk(ipl_n == ~3'(hi), "R1 R2 priority encode", ipl_n, ~3'(hi));
    end
    @(negedge clk);
    req_n = '1;
  endtask

  task automatic t_load_vectors();
    // R9: write each level, then read back through acknowledge
    for (int l = 1; l <= 7; l++) begin
      @(negedge clk);
      vec_wr = 1'b1; vec_lvl = 3'(l); vec_wdata = 8'hA0 + 8'(l * 5);
      exp_vec[l] = 8'hA0 + 8'(l * 5);
    end
    @(negedge clk);
    vec_wr = 1'b0;
    for (int l = 7; l >= 1; l--) bus_cycle(3'b111, iack_addr(l), l, "R3 R7 R9 vector return");
  endtask

  task automatic t_level0_write();
    // R9: write to level 0 changes nothing
    @(negedge clk);
    vec_wr = 1'b1; vec_lvl = 3'd0; vec_wdata = 8'hEE;
    @(negedge clk);
    vec_wr = 1'b0;
    for (int l = 1; l <= 7; l++) bus_cycle(3'b111, iack_addr(l), l, "R9 level0 write ignored");
  endtask

  task automatic t_bad_cycles();
    bus_cycle(3'b001, iack_addr(4), 0, "R4 user data fc");
    bus_cycle(3'b010, iack_addr(4), 0, "R4 user program fc");
    bus_cycle(3'b101, iack_addr(5), 0, "R4 supervisor data fc");
    bus_cycle(3'b110, iack_addr(6), 0, "R4 supervisor program fc");
    bus_cycle(3'b111, {20'hFFFFE, 3'd3}, 0, "R6 upper address not ones");
    bus_cycle(3'b111, {20'h7FFFF, 3'd3}, 0, "R6 top address bit low");
    bus_cycle(3'b111, iack_addr(0), 0, "R6 level zero in address");
    // R5: strobe high with valid iack code
    @(negedge clk);
    fc = 3'b111; addr = iack_addr(2); as_n = 1'b1;
    #1;
    chk(ack_n == 7'h7F, "R5 strobe high", ack_n, 7'h7F);
    chk(vec_oe == 1'b0, "R5 strobe high oe", vec_oe, 0);
    @(negedge clk);
    fc = 3'b001;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_encode_all();
    t_load_vectors();
    t_level0_write();
    t_bad_cycles();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule